// File: doc/BRIEF.md
# Parallel ADC Host Read Controller

This block sits on the host side of an external successive-approximation converter that has a parallel output bus. It drives the converter's active-low start-of-conversion strobe and waits for the converter's BUSY line to drop. It then pulls chip-select and read low together, samples the result bus after a programmable access delay, and hands the sample to downstream logic as a one-cycle valid pulse with data. Which converter is attached, 10-bit or 12-bit, is set by a width parameter.

The controller follows the converter's handshake. After reset it runs one conversion of its own and throws the result away, because the first conversion after power-up is not reliable. It keeps a minimum acquisition gap, counted in clock cycles, between the end of one conversion and the start of the next. It never issues a read while BUSY is high. A sample request that arrives while a conversion or read is in progress is held and served afterwards. If BUSY does not fall within a timeout window, the controller raises an error flag and returns to idle.

BUSY comes from another device, so it passes through a synchronizer of `SYNC_STAGES` flops before the controller acts on it.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `convst_n_o`, `cs_n_o` and `rd_n_o` are 1, and `valid_o` and `err_o` are 0.
- R2: Each conversion start holds `convst_n_o` low for exactly `CONV_LOW_CYC` clock cycles, and no read strobe is active during that pulse.
- R3: After reset the controller starts one conversion without any request. That conversion's read produces no `valid_o` pulse.
- R4: `cs_n_o` and `rd_n_o` are always equal. They go low only after a falling edge of BUSY has been detected, and never while the synchronized BUSY is high.
- R5: `data_o` is the value on `bus_i` at the clock edge `RD_SETUP_CYC` edges after the edge that drove `rd_n_o` low. On that edge the strobes return high and `valid_o` rises for the following cycle.
- R6: At least `ACQ_CYC` clock cycles separate a BUSY fall from the next falling edge of `convst_n_o`.
- R7: A `req_i` pulse that arrives while a conversion or read is in progress is held. It starts another conversion once the current one has finished and the acquisition gap has passed.
- R8: If BUSY does not fall within `BUSY_TIMEOUT` cycles after the start pulse ends, `err_o` is set and the controller returns to idle with all strobes high. `err_o` stays set until the next completed read clears it.
- R9: `valid_o` is never high for two consecutive cycles. Each served request yields exactly one `valid_o` pulse. Requests made while one is already held merge into a single conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Sample request pulse |
| busy_i | input | 1 | Converter BUSY, high during conversion (asynchronous) |
| bus_i | input | DATA_W | Converter parallel result bus |
| convst_n_o | output | 1 | Active-low conversion start strobe |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| data_o | output | DATA_W | Captured sample |
| valid_o | output | 1 | One-cycle pulse marking a new sample on `data_o` |
| err_o | output | 1 | Sticky BUSY-timeout flag |

## Verification
The embedded properties check on every cycle the rules that can be judged in one cycle or across two:
- chip-select and read always move together;
- no read happens while synchronized BUSY is high;
- the start pulse never overlaps a read;
- a start edge only comes once the acquisition counter has expired;
- a timeout leaves the strobes idle;
- valid is a single-cycle pulse that follows a read.

Other behaviours only show up in the bench's scenarios against a behavioural converter:
- the exact start-pulse width and the acquisition gap measured at the pins;
- that the dummy conversion is discarded;
- correct data capture under the model's access delay;
- that requests are held and merged;
- error recovery.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2,
        ST_READ  = 2'd3
    } rd_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic fell
);
    logic [STAGES:0] chain;
    logic            prev_q;

    assign chain[0] = din;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= chain[g];
            end
            assign chain[g+1] = stage_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain[STAGES];
    end

    assign dout = chain[STAGES];
    assign fell = prev_q & ~chain[STAGES];
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = load_val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W       = 12,
    parameter int CONV_LOW_CYC = 2,
    parameter int ACQ_CYC      = 14,
    parameter int RD_SETUP_CYC = 2,
    parameter int BUSY_TIMEOUT = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              convst_n_o,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int PH_MAX = max3(CONV_LOW_CYC, RD_SETUP_CYC, BUSY_TIMEOUT);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int ACQ_W  = $clog2(ACQ_CYC + 1);

    typedef struct packed {
        rd_state_e         st;
        logic              pend;
        logic              dummy;
        logic              err;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              convst_n;
        logic              cs_n;
        logic              rd_n;
    } ctrl_t;

    ctrl_t            r_d, r_q;
    logic             busy_s, busy_fell;
    logic             ph_load, ph_zero;
    logic [PH_W-1:0]  ph_val;
    logic             acq_load, acq_zero;

    adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(busy_i), .dout(busy_s), .fell(busy_fell)
    );

    adc_rd_timer #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    adc_rd_timer #(.W(ACQ_W)) u_acq (
        .clk(clk), .rst_n(rst_n), .load(acq_load),
        .load_val(ACQ_W'(ACQ_CYC)), .zero(acq_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.valid = 1'b0;
        ph_load  = 1'b0;
        ph_val   = '0;
        acq_load = 1'b0;
        if (req_i) r_d.pend = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if ((r_q.pend || req_i || r_q.dummy) && acq_zero) begin
                    r_d.st  = ST_START;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(CONV_LOW_CYC - 1);
                    if (!r_q.dummy) r_d.pend = 1'b0;
                end
            end
            ST_START: begin
                if (ph_zero) begin
                    r_d.st  = ST_WAIT;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(BUSY_TIMEOUT);
                end
            end
            ST_WAIT: begin
                if (busy_fell) begin
                    r_d.st   = ST_READ;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(RD_SETUP_CYC - 1);
                    acq_load = 1'b1;
                end else if (ph_zero) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end
            end
            ST_READ: begin
                if (ph_zero) begin
                    r_d.st    = ST_IDLE;
                    r_d.data  = bus_i;
                    r_d.valid = !r_q.dummy;
                    r_d.dummy = 1'b0;
                    r_d.err   = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        r_d.convst_n = (r_d.st != ST_START);
        r_d.cs_n     = (r_d.st != ST_READ);
        r_d.rd_n     = !(r_d.st == ST_READ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.dummy    <= 1'b1;
            r_q.convst_n <= 1'b1;
            r_q.cs_n     <= 1'b1;
            r_q.rd_n     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign convst_n_o = r_q.convst_n;
    assign cs_n_o     = r_q.cs_n;
    assign rd_n_o     = r_q.rd_n;
    assign data_o     = r_q.data;
    assign valid_o    = r_q.valid;
    assign err_o      = r_q.err;

    // R4: strobes move together and never while converter busy
    p_strobe_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o == rd_n_o);
    p_no_read_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !busy_s);
    // R2: start pulse never overlaps a read
    p_start_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !convst_n_o |-> rd_n_o);
    // R6: start edge only after acquisition counter expired
    p_acq_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convst_n_o) |-> $past(acq_zero));
    // R8: a timeout leaves all strobes idle
    p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (convst_n_o && rd_n_o && !valid_o));
    // R9: valid is a single-cycle pulse
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R5: valid follows a read
    p_valid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(!rd_n_o));
endmodule

// File: tb/sim_adc_rd_ctrl.sv
module sim_adc_rd_ctrl;
    localparam int PERIOD       = 10;
    localparam int DATA_W       = 12;
    localparam int CONV_LOW_CYC = 2;
    localparam int ACQ_CYC      = 14;
    localparam int RD_SETUP_CYC = 2;
    localparam int BUSY_TIMEOUT = 64;
    localparam int CONV_CYC     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_i = 1'b0;
    logic              busy_i = 1'b0;
    logic [DATA_W-1:0] bus_i;
    logic              convst_n_o, cs_n_o, rd_n_o, valid_o, err_o;
    logic [DATA_W-1:0] data_o;

    int errors = 0;
    int checks = 0;
    int n_valid = 0;
    int n_conv = 0;
    bit stuck = 1'b0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    adc_rd_ctrl #(
        .DATA_W(DATA_W), .CONV_LOW_CYC(CONV_LOW_CYC), .ACQ_CYC(ACQ_CYC),
        .RD_SETUP_CYC(RD_SETUP_CYC), .BUSY_TIMEOUT(BUSY_TIMEOUT), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_i(busy_i), .bus_i(bus_i),
        .convst_n_o(convst_n_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
        .data_o(data_o), .valid_o(valid_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] sample_val(input int k);
        return DATA_W'((k * 1103 + 517) ^ (k << 5));
    endfunction

    // Behavioural converter
    logic              cv_prev = 1'b1;
    int                conv_cnt = 0;
    int                acc_cnt = 0;
    logic [DATA_W-1:0] result = '0;
    logic [DATA_W-1:0] exp_q[$];

    always @(posedge clk) begin
        cv_prev <= convst_n_o;
        acc_cnt <= (!cs_n_o && !rd_n_o) ? acc_cnt + 1 : 0;
        if (cv_prev && !convst_n_o && !stuck && !busy_i) begin
            busy_i   <= 1'b1;
            conv_cnt <= CONV_CYC;
        end else if (busy_i) begin
            conv_cnt <= conv_cnt - 1;
            if (conv_cnt == 1) begin
                busy_i <= 1'b0;
                result <= sample_val(n_conv);
                exp_q.push_back(sample_val(n_conv));
                n_conv <= n_conv + 1;
            end
        end
    end

    assign bus_i = (!cs_n_o && !rd_n_o && acc_cnt >= RD_SETUP_CYC - 1) ? result : ~result;

    // Pin monitors
    int  low_w = 0;
    int  gap = 0;
    bit  armed = 1'b0;
    logic p_conv = 1'b1, p_busy = 1'b0, p_valid = 1'b0;
    bit  dummy_pending = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!convst_n_o) low_w++;
            if (!p_conv && convst_n_o) begin
                check(low_w == CONV_LOW_CYC, "R2", "start pulse width", low_w, CONV_LOW_CYC);
                low_w = 0;
            end
            if (armed) gap++;
            if (p_busy && !busy_i) begin gap = 0; armed = 1'b1; end
            if (p_conv && !convst_n_o && armed) begin
                check(gap >= ACQ_CYC, "R6", "acquisition gap", gap, ACQ_CYC);
                armed = 1'b0;
            end
            if (cs_n_o != rd_n_o) check(1'b0, "R4", "cs/rd mismatch", cs_n_o, rd_n_o);
            if (!rd_n_o && busy_i) check(1'b0, "R4", "read while busy", 1, 0);
            if (p_valid && valid_o) check(1'b0, "R9", "valid two cycles", 2, 1);
            if (valid_o) begin
                n_valid++;
                if (exp_q.size() > 0) begin
                    check(data_o == exp_q[0], "R5", "captured data", data_o, exp_q[0]);
                    void'(exp_q.pop_front());
                end else check(1'b0, "R5", "unexpected valid", 1, 0);
            end
            p_conv  = convst_n_o;
            p_busy  = busy_i;
            p_valid = valid_o;
        end
    end

    task automatic pulse_req();
        @(posedge clk); req_i <= 1'b1;
        @(posedge clk); req_i <= 1'b0;
    endtask

    task automatic wait_valids(input int target, input string req);
        int t = 0;
        while (n_valid < target && t < 400) begin @(negedge clk); t++; end
        check(n_valid == target, req, "valid count", n_valid, target);
    endtask

    task automatic idle_gap(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int target;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1 during reset
        check(convst_n_o && cs_n_o && rd_n_o, "R1", "strobes high in reset",
              {convst_n_o, cs_n_o, rd_n_o}, 7);
        check(!valid_o && !err_o, "R1", "flags low in reset", {valid_o, err_o}, 0);
        @(posedge clk); rst_n <= 1'b1;
        @(negedge clk);
        check(convst_n_o && rd_n_o && !err_o && !valid_o, "R1", "state after reset",
              {convst_n_o, rd_n_o, err_o, valid_o}, 12);

        // R3: dummy conversion runs unrequested and is discarded
        while (n_conv < 1) @(negedge clk);
        idle_gap(ACQ_CYC + 10);
        check(n_valid == 0, "R3", "dummy produced valid", n_valid, 0);
        check(n_conv == 1, "R3", "dummy conversion ran", n_conv, 1);
        if (exp_q.size() > 0) void'(exp_q.pop_front());

        // Single request
        pulse_req();
        wait_valids(1, "R5");

        // R7: request held during conversion
        idle_gap(ACQ_CYC + 10);
        pulse_req();
        idle_gap(6);
        pulse_req();
        wait_valids(3, "R7");

        // R9: several requests during one conversion merge
        idle_gap(ACQ_CYC + 10);
        pulse_req();
        idle_gap(3); pulse_req(); pulse_req(); pulse_req();
        wait_valids(5, "R9");
        idle_gap(ACQ_CYC + 60);
        check(n_valid == 5, "R9", "merged requests", n_valid, 5);

        // Constrained random sequences
        target = n_valid;
        for (int i = 0; i < 40; i++) begin
            idle_gap(ACQ_CYC + 10 + int'($urandom_range(0, 20)));
            pulse_req();
            target++;
            if ($urandom_range(0, 1) == 1) begin
                idle_gap(int'($urandom_range(1, 10)));
                pulse_req();
                target++;
            end
            wait_valids(target, "R7");
        end

        // R8: timeout, then recovery
        idle_gap(ACQ_CYC + 10);
        stuck = 1'b1;
        pulse_req();
        idle_gap(BUSY_TIMEOUT + CONV_LOW_CYC + 10);
        check(err_o == 1'b1, "R8", "error flag set", err_o, 1);
        check(convst_n_o && cs_n_o && rd_n_o, "R8", "strobes idle after timeout",
              {convst_n_o, cs_n_o, rd_n_o}, 7);
        check(n_valid == target, "R8", "no valid on timeout", n_valid, target);
        stuck = 1'b0;
        idle_gap(5);
        pulse_req();
        target++;
        wait_valids(target, "R8");
        @(negedge clk);
        check(err_o == 1'b0, "R8", "error cleared by read", err_o, 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule